// File: doc/BRIEF.md
# Four-Lane SD Read Data Block Receiver

This block takes in one data block from the four-line SD data bus after the command path reports that a command has finished. The command path states the kind of data phase that will follow. In a block phase the receiver waits a bounded time for a start nibble. It then stores every data nibble in a nibble-addressed buffer and runs a separate serial CRC16 on each line. After the check nibbles it checks for an all-ones end nibble.

A block is accepted only when all four CRC residues are zero. An accepted block is streamed out one nibble per cycle, with a valid flag and a pulse on the final nibble, and the whole buffer is also visible as one flat word. A busy phase instead watches line 0 until the card releases it. Each phase ends with a one-cycle done pulse, whether it succeeded, failed its check or timed out.

Top module: `sd_dat_block_rx`

## Requirements
- R1: `duse_mode` is sampled with `cmd_done` and uses this code: 2'b00 no data phase, 2'b01 busy wait, 2'b10 wide status data of `WIDE_NIB` nibbles, 2'b11 single block of `BLK_NIB` nibbles. A `cmd_done` with code 2'b00 changes no output.
- R2: `dat_in` is captured in a 4-bit sample register. In a data phase, the first sampled nibble with all four lines 0 is the start nibble. The nibble sampled after it is data nibble 0.
- R3: In a data phase, if no start nibble arrives, `tmo_err` rises and `done` pulses at the `TIMEOUT`+1st clock edge after the edge that accepted `cmd_done`. The timeout is counted by a down-counting `TMR_W`-bit timer.
- R4: Data nibble i is written to buffer entry i. After the block, `blk_data[4*i+3:4*i]` holds it, with bit k taken from line k.
- R5: Each line runs its own CRC16, polynomial 0x1021, initial value zero, most significant bit first. The 16 check nibbles follow the data, and bit k of each check nibble belongs to line k. The block is accepted only if all four residues are zero and the nibble after the check bits is 4'hF. Otherwise `crc_err` is set.
- R6: After an accepted block, `rd_valid` is high for exactly the block length in consecutive cycles, starting in the `done` cycle. `rd_nib` presents entries 0, 1, 2 and so on in order. `rd_last` pulses only with the final nibble. A rejected block or a timeout gives no stream.
- R7: In busy mode, `done` pulses without error once line 0 is sampled high. If line 0 stays low, the mode times out exactly as in R3.
- R8: In wide mode, the length is `WIDE_NIB` nibbles for the CRC position, the end nibble and the stream.
- R9: `done` is a single-cycle pulse. `crc_err` and `tmo_err` hold their value until the next accepted `cmd_done`, which clears them. They are never both set.
- R10: A `cmd_done` that arrives while a phase is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one bus nibble per cycle |
| rst | input | 1 | Synchronous reset, active high |
| cmd_done | input | 1 | One-cycle pulse: the command has finished |
| duse_mode | input | 2 | Kind of data phase (R1) |
| dat_in | input | LANES | SD data lines |
| rd_nib | output | LANES | Streamed nibble |
| rd_valid | output | 1 | `rd_nib` is valid |
| rd_last | output | 1 | Final nibble of the stream |
| blk_data | output | BLK_NIB*LANES | Whole buffer, entry i at bits 4i upward |
| done | output | 1 | Phase finished (success, CRC error or timeout) |
| crc_err | output | 1 | Block rejected by CRC or end nibble |
| tmo_err | output | 1 | Start or busy release not seen in time |

## Verification
The checker watches, on every cycle, the shape of the handshake. It verifies that `done` lasts one cycle, that the two error flags are exclusive and keep their value until a new command, that the stream never breaks before `rd_last`, and that it ends right after `rd_last`. Only the bench scenarios can show that the right data arrives. Those scenarios cover nibble order in the stream and the flat word, acceptance or rejection against CRCs computed independently, the exact timeout cycle, wide versus single-block length, busy release, and the ignored commands.

// File: rtl/sd_rx_pkg.sv
package sd_rx_pkg;

   typedef enum logic [1:0] {
      DUSE_NONE  = 2'b00,
      DUSE_BUSY  = 2'b01,
      DUSE_WIDE  = 2'b10,
      DUSE_BLOCK = 2'b11
   } duse_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_DATA,
      ST_CHECK,
      ST_END,
      ST_STREAM,
      ST_BUSY
   } rx_state_t;

endpackage

// File: rtl/sd_rx_lane_crc.sv
module sd_rx_lane_crc #(
   parameter int             CRC_W    = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             bit_in,
   output logic [CRC_W-1:0] crc
);

   logic             fb;
   logic [CRC_W-1:0] crc_nxt;

   always_comb begin
      fb      = bit_in ^ crc[CRC_W-1];
      crc_nxt = {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
   end

   always_ff @(posedge clk) begin
      if (clr)
         crc <= '0;
      else if (en)
         crc <= crc_nxt;
   end

endmodule

// File: rtl/sd_rx_nib_buf.sv
module sd_rx_nib_buf #(
   parameter int NW    = 4,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                we,
   input  logic [AW-1:0]       addr,
   input  logic [NW-1:0]       wdata,
   output logic [NW-1:0]       rdata,
   output logic [DEPTH*NW-1:0] flat
);

   logic [NW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign flat[g*NW +: NW] = mem[g];
   end

endmodule

// File: rtl/sd_rx_ctrl.sv
module sd_rx_ctrl
   import sd_rx_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int BLK_NIB  = 1024,
   parameter int WIDE_NIB = 128,
   parameter int CRC_W    = 16,
   parameter int TMR_W    = 23,
   parameter int TIMEOUT  = 100000,
   localparam int AW      = $clog2(BLK_NIB),
   localparam int CNT_W   = AW + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_done,
   input  logic [1:0]       duse_mode,
   input  logic [LANES-1:0] dat_q,
   input  logic             crc_ok,
   output logic             smp_en,
   output logic             buf_we,
   output logic [AW-1:0]    buf_addr,
   output logic             crc_clr,
   output logic             crc_en,
   output logic             done,
   output logic             crc_err,
   output logic             tmo_err,
   output logic             rd_valid,
   output logic             rd_last
);

   localparam logic [CNT_W-1:0] BLK_LAST  = CNT_W'(BLK_NIB - 1);
   localparam logic [CNT_W-1:0] WIDE_LAST = CNT_W'(WIDE_NIB - 1);
   localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_W - 1);
   localparam logic [TMR_W-1:0] TMR_LOAD  = TMR_W'(TIMEOUT);

   rx_state_t        st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_idx;
   logic [TMR_W-1:0] tmr;
   logic             accept;

   assign accept = (st == ST_IDLE) && cmd_done && (duse_mode != DUSE_NONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         last_idx <= '0;
         tmr      <= '0;
         done     <= 1'b0;
         crc_err  <= 1'b0;
         tmo_err  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  crc_err  <= 1'b0;
                  tmo_err  <= 1'b0;
                  tmr      <= TMR_LOAD;
                  cnt      <= '0;
                  last_idx <= (duse_mode == DUSE_WIDE) ? WIDE_LAST : BLK_LAST;
                  st       <= (duse_mode == DUSE_BUSY) ? ST_BUSY : ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (dat_q == '0) begin
                  cnt <= '0;
                  st  <= ST_DATA;
               end else if (tmr == '0) begin
                  tmo_err <= 1'b1;
                  done    <= 1'b1;
                  st      <= ST_IDLE;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == last_idx) begin
                  cnt <= '0;
                  st  <= ST_CHECK;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CHECK: begin
               if (cnt == CRC_LAST) begin
                  cnt <= '0;
                  st  <= ST_END;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_END: begin
               done <= 1'b1;
               if (crc_ok && (dat_q == '1)) begin
                  cnt <= '0;
                  st  <= ST_STREAM;
               end else begin
                  crc_err <= 1'b1;
                  st      <= ST_IDLE;
               end
            end
            ST_STREAM: begin
               if (cnt == last_idx)
                  st <= ST_IDLE;
               else
                  cnt <= cnt + 1'b1;
            end
            ST_BUSY: begin
               if (dat_q[0]) begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
               end else if (tmr == '0) begin
                  tmo_err <= 1'b1;
                  done    <= 1'b1;
                  st      <= ST_IDLE;
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      smp_en   = (st != ST_IDLE) || cmd_done;
      buf_we   = (st == ST_DATA);
      crc_en   = (st == ST_DATA) || (st == ST_CHECK);
      crc_clr  = accept;
      buf_addr = cnt[AW-1:0];
      rd_valid = (st == ST_STREAM);
      rd_last  = (st == ST_STREAM) && (cnt == last_idx);
   end

endmodule

// File: rtl/sd_dat_block_rx.sv
module sd_dat_block_rx #(
   parameter int               LANES    = 4,
   parameter int               BLK_NIB  = 1024,
   parameter int               WIDE_NIB = 128,
   parameter int               CRC_W    = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
   parameter int               TMR_W    = 23,
   parameter int               TIMEOUT  = 100000
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cmd_done,
   input  logic [1:0]               duse_mode,
   input  logic [LANES-1:0]         dat_in,
   output logic [LANES-1:0]         rd_nib,
   output logic                     rd_valid,
   output logic                     rd_last,
   output logic [BLK_NIB*LANES-1:0] blk_data,
   output logic                     done,
   output logic                     crc_err,
   output logic                     tmo_err
);

   localparam int AW = $clog2(BLK_NIB);

   if (WIDE_NIB > BLK_NIB || WIDE_NIB < 1) begin : g_bad_wide
      $error("WIDE_NIB must lie in 1..BLK_NIB");
   end
   if (BLK_NIB < CRC_W || (1 << AW) != BLK_NIB) begin : g_bad_blk
      $error("BLK_NIB must be a power of two no smaller than CRC_W");
   end
   if (TMR_W < 2 || TMR_W > 31 || TIMEOUT >= (1 << TMR_W) || TIMEOUT < 1) begin : g_bad_tmr
      $error("TIMEOUT must fit the TMR_W-bit timer");
   end

   logic [LANES-1:0]       dat_q;
   logic                   smp_en;
   logic                   buf_we;
   logic [AW-1:0]          buf_addr;
   logic                   crc_clr;
   logic                   crc_en;
   logic [LANES*CRC_W-1:0] residues;
   logic                   crc_ok;

   always_ff @(posedge clk) begin
      if (rst)
         dat_q <= '1;
      else if (smp_en)
         dat_q <= dat_in;
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      sd_rx_lane_crc #(
         .CRC_W    (CRC_W),
         .CRC_POLY (CRC_POLY)
      ) u_crc (
         .clk    (clk),
         .clr    (rst | crc_clr),
         .en     (crc_en),
         .bit_in (dat_q[ln]),
         .crc    (residues[ln*CRC_W +: CRC_W])
      );
   end

   assign crc_ok = (residues == '0);

   sd_rx_nib_buf #(
      .NW    (LANES),
      .DEPTH (BLK_NIB)
   ) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .addr  (buf_addr),
      .wdata (dat_q),
      .rdata (rd_nib),
      .flat  (blk_data)
   );

   sd_rx_ctrl #(
      .LANES    (LANES),
      .BLK_NIB  (BLK_NIB),
      .WIDE_NIB (WIDE_NIB),
      .CRC_W    (CRC_W),
      .TMR_W    (TMR_W),
      .TIMEOUT  (TIMEOUT)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .cmd_done  (cmd_done),
      .duse_mode (duse_mode),
      .dat_q     (dat_q),
      .crc_ok    (crc_ok),
      .smp_en    (smp_en),
      .buf_we    (buf_we),
      .buf_addr  (buf_addr),
      .crc_clr   (crc_clr),
      .crc_en    (crc_en),
      .done      (done),
      .crc_err   (crc_err),
      .tmo_err   (tmo_err),
      .rd_valid  (rd_valid),
      .rd_last   (rd_last)
   );

endmodule

// File: rtl/sd_rx_chk.sv
module sd_rx_chk (
   input logic clk,
   input logic rst,
   input logic cmd_done,
   input logic done,
   input logic crc_err,
   input logic tmo_err,
   input logic rd_valid,
   input logic rd_last
);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R9
   err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(crc_err && tmo_err));

   // R9
   crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (crc_err && !cmd_done) |=> crc_err);

   // R9
   tmo_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (tmo_err && !cmd_done) |=> tmo_err);

   // R6
   last_in_stream_chk: assert property (@(posedge clk) disable iff (rst)
      rd_last |-> rd_valid);

   // R6
   stream_end_chk: assert property (@(posedge clk) disable iff (rst)
      rd_last |=> !rd_valid);

   // R6
   stream_gapless_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && !rd_last) |=> rd_valid);

   // R3
   no_stream_on_timeout_chk: assert property (@(posedge clk) disable iff (rst)
      tmo_err |-> !rd_valid);

endmodule

bind sd_dat_block_rx sd_rx_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .cmd_done (cmd_done),
   .done     (done),
   .crc_err  (crc_err),
   .tmo_err  (tmo_err),
   .rd_valid (rd_valid),
   .rd_last  (rd_last)
);

// File: tb/sim_sd_dat_block_rx.sv
module sim_sd_dat_block_rx;

   localparam int CLK_P = 10;
   localparam int BLK   = 32;
   localparam int WIDE  = 16;
   localparam int TMO   = 40;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           cmd_done = 1'b0;
   logic [1:0]     duse_mode = 2'b00;
   logic [3:0]     dat_in = 4'hF;
   logic [3:0]     rd_nib;
   logic           rd_valid, rd_last;
   logic [BLK*4-1:0] blk_data;
   logic           done, crc_err, tmo_err;

   int total = 0;
   int bad   = 0;
   bit fin   = 0;

   logic [3:0]  d [BLK];
   logic [15:0] lcrc [4];

   always #(CLK_P/2) clk = ~clk;

   sd_dat_block_rx #(
      .LANES(4), .BLK_NIB(BLK), .WIDE_NIB(WIDE), .CRC_W(16),
      .CRC_POLY(16'h1021), .TMR_W(23), .TIMEOUT(TMO)
   ) u0 (
      .clk(clk), .rst(rst), .cmd_done(cmd_done), .duse_mode(duse_mode),
      .dat_in(dat_in), .rd_nib(rd_nib), .rd_valid(rd_valid), .rd_last(rd_last),
      .blk_data(blk_data), .done(done), .crc_err(crc_err), .tmo_err(tmo_err)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fill(input int len, input int mul, input int add);
      for (int i = 0; i < BLK; i++) d[i] = 4'((i * mul + add) & 15);
      for (int ln = 0; ln < 4; ln++) begin
         int c = 0;
         for (int i = 0; i < len; i++) begin
            int b = (d[i] >> ln) & 1;
            if ((((c >> 15) & 1) ^ b) != 0) c = ((c << 1) ^ 'h1021) & 'hFFFF;
            else c = (c << 1) & 'hFFFF;
         end
         lcrc[ln] = 16'(c);
      end
   endtask

   task automatic issue(input logic [1:0] m);
      @(negedge clk);
      duse_mode = m;
      cmd_done  = 1'b1;
      @(negedge clk);
      cmd_done  = 1'b0;
   endtask

   // len: nibbles, m: mode code, gap: idle cycles, bad_idx: corrupted nibble (-1 none),
   // bad_end: wrong end nibble, stray: extra cmd_done in mid data
   task automatic run_block(input string req, input int len, input logic [1:0] m,
                            input int gap, input int bad_idx, input bit bad_end,
                            input bit stray);
      bit ok = (bad_idx < 0) && !bad_end;
      int seen = 0;
      dat_in = 4'hF;
      issue(m);
      for (int g = 0; g < gap; g++) @(negedge clk);
      dat_in = 4'h0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         dat_in   = (i == bad_idx) ? (d[i] ^ 4'h4) : d[i];
         cmd_done = stray && (i == 3);
      end
      cmd_done = 1'b0;
      for (int b = 15; b >= 0; b--) begin
         @(negedge clk);
         dat_in = {lcrc[3][b], lcrc[2][b], lcrc[1][b], lcrc[0][b]};
      end
      @(negedge clk);
      dat_in = bad_end ? 4'hE : 4'hF;
      @(negedge clk);
      dat_in = 4'hF;
      for (int w = 0; w < 10 && !done; w++) @(negedge clk);
      chk({req, " done pulse"}, done, 1);
      chk({req, " crc_err"}, crc_err, !ok);
      chk({req, " tmo_err"}, tmo_err, 0);
      if (ok) begin
         for (int i = 0; i < len; i++) begin
            chk({req, " R6 rd_valid"}, rd_valid, 1);
            chk({req, " R6 rd_nib"}, rd_nib, d[i]);
            chk({req, " R6 rd_last"}, rd_last, (i == len - 1));
            @(negedge clk);
         end
         chk({req, " R6 stream end"}, rd_valid, 0);
         for (int i = 0; i < len; i++)
            chk({req, " R4 blk_data"}, blk_data[i*4 +: 4], d[i]);
      end else begin
         for (int i = 0; i < 4; i++) begin
            if (rd_valid) seen++;
            @(negedge clk);
         end
         chk({req, " R6 no stream"}, seen, 0);
      end
   endtask

   task automatic time_out(input string req, input logic [1:0] m, input logic [3:0] idle);
      int n = 0;
      dat_in = idle;
      @(negedge clk);
      duse_mode = m;
      cmd_done  = 1'b1;
      while (n < TMO + 10) begin
         @(negedge clk);
         cmd_done = 1'b0;
         n++;
         if (done) break;
      end
      chk({req, " timeout edge"}, n, TMO + 2);
      chk({req, " tmo_err"}, tmo_err, 1);
      chk({req, " crc_err"}, crc_err, 0);
      dat_in = 4'hF;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!fin) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("reset done", done, 0);
      chk("reset crc_err", crc_err, 0);
      chk("reset tmo_err", tmo_err, 0);
      chk("reset rd_valid", rd_valid, 0);
      chk("reset rd_last", rd_last, 0);

      // R5 R2 R4 block mode, several data patterns and start gaps
      fill(BLK, 1, 0);  run_block("R5 R2 incr", BLK, 2'b11, 0, -1, 0, 0);
      fill(BLK, 7, 3);  run_block("R5 R2 mul7", BLK, 2'b11, 5, -1, 0, 0);
      fill(BLK, 0, 0);  run_block("R5 zeros", BLK, 2'b11, 2, -1, 0, 0);
      fill(BLK, 0, 15); run_block("R5 ones", BLK, 2'b11, 1, -1, 0, 0);
      fill(BLK, 5, 9);  run_block("R5 R2 mul5", BLK, 2'b11, 12, -1, 0, 0);

      // R8 wide mode uses the shorter length
      fill(WIDE, 3, 1); run_block("R8 wide", WIDE, 2'b10, 3, -1, 0, 0);
      fill(WIDE, 11, 6); run_block("R8 wide2", WIDE, 2'b10, 0, -1, 0, 0);

      // R5 rejection: corrupted nibble, bad end nibble
      fill(BLK, 9, 2);  run_block("R5 corrupt", BLK, 2'b11, 2, 10, 0, 0);
      fill(BLK, 9, 2);  run_block("R5 corrupt last", BLK, 2'b11, 2, BLK - 1, 0, 0);
      fill(BLK, 9, 2);  run_block("R5 end nibble", BLK, 2'b11, 2, -1, 1, 0);

      // R1 R9 mode none is ignored, error flag stays
      issue(2'b00);
      begin
         int dn = 0;
         for (int i = 0; i < TMO + 8; i++) begin
            @(negedge clk);
            if (done || rd_valid) dn++;
         end
         chk("R1 none no done", dn, 0);
         chk("R9 R1 crc_err held", crc_err, 1);
      end

      // R10 stray cmd_done during reception is ignored
      fill(BLK, 13, 4); run_block("R10 stray", BLK, 2'b11, 1, -1, 0, 1);

      // R3 start never arrives
      time_out("R3 block", 2'b11, 4'hF);
      time_out("R3 wide", 2'b10, 4'h8);

      // R7 busy mode: release after some cycles, and timeout
      dat_in = 4'hE;
      issue(2'b01);
      repeat (6) @(negedge clk);
      chk("R7 busy held no done", done, 0);
      dat_in = 4'hF;
      begin
         int w = 0;
         while (!done && w < 10) begin @(negedge clk); w++; end
      end
      chk("R7 busy done", done, 1);
      chk("R7 R9 busy clears tmo_err", tmo_err, 0);
      chk("R7 busy crc_err", crc_err, 0);
      time_out("R7 busy", 2'b01, 4'hE);

      // R9 next good block clears the timeout flag
      fill(BLK, 2, 7);  run_block("R9 recover", BLK, 2'b11, 0, -1, 0, 0);

      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule